// File: doc/BRIEF.md
# Memory Region Access Guard

This block decides, for every memory access that a core presents, whether the access may proceed. Up to eight regions can be programmed. Each region is a naturally aligned block whose size is a power of two, cut into eight equal sub-regions, any of which can be masked out. An access carries an address, a kind (read, write or execute) and a privilege flag. The block looks for the highest-numbered enabled region that covers the address, applies that region's permission code and execute-never bit, and returns a permit or a fault one clock later, together with the number of the region that decided.

Software sets up the regions through a simple write port: one region entry per write, selected by an index. A separate control write sets the global enable and the privileged background map. When the guard is globally off, everything is permitted. When it is on and no region claims the address, only privileged accesses can pass, and only if the background map is on. The fault output is a one-cycle pulse; raising the exception is left to the surrounding logic.

Top module: `mem_region_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all result outputs are 0; every region is disabled and both the global enable and the background map are off.
- R2: A result appears exactly one clock after the access strobe: `res_valid` follows `acc_valid` with one cycle delay, and when `res_valid` is 0 the outputs `res_permit`, `res_fault`, `res_hit` and `res_region` are all 0. When `res_valid` is 1 exactly one of `res_permit` and `res_fault` is 1.
- R3: A region with size code `lg` covers the 2^lg bytes whose address agrees with the region base in bits [31:lg]; `lg` is held between 5 (32 bytes) and 32 (whole 4 GB space), a written code below 5 is stored as 5 and one above 32 as 32.
- R4: When several enabled regions cover an address, the one with the highest index decides, and its index is reported on `res_region` with `res_hit` = 1.
- R5: Address bits [lg-1:lg-3] pick a sub-region; if bit k of the region's disable mask is 1, sub-region k counts as not covered by that region, so a lower-numbered region or the background rule applies instead.
- R6: Access kind encoding: 00 read, 01 write, 10 and 11 execute. Permission code: 000 nothing; 001 privileged read/write; 010 privileged read/write, unprivileged read; 011 all read/write; 101 privileged read only; 110 read only for both; 100 and 111 nothing. Execute is allowed where read is allowed and the region's execute-never bit is 0.
- R7: With the guard on, an access that no region covers, or that the deciding region forbids, gives `res_fault` = 1.
- R8: With the guard on and the background map on, a privileged access covered by no region is permitted with `res_hit` = 0 and `res_region` = 0; an unprivileged one still faults.
- R9: With the global enable off, every access is permitted with `res_hit` = 0 and `res_region` = 0.
- R10: Base address bits below the region size are ignored; an unaligned base behaves as its aligned-down value.
- R11: A region or control write takes effect from the next clock; an access in the same cycle as the write is judged with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write one region entry |
| cfg_idx | input | 3 | Index of the region written |
| cfg_base | input | 32 | Region base address |
| cfg_size_lg | input | 6 | Region size as log2 of bytes |
| cfg_on | input | 1 | Region enable |
| cfg_sub_off | input | 8 | Sub-region disable mask |
| cfg_perm | input | 3 | Permission code |
| cfg_xn | input | 1 | Execute-never |
| ctl_we | input | 1 | Write the control settings |
| ctl_guard_en | input | 1 | Global enable |
| ctl_bg_en | input | 1 | Privileged background map enable |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | Access kind |
| acc_priv | input | 1 | Access is privileged |
| res_valid | output | 1 | Result valid |
| res_permit | output | 1 | Access allowed |
| res_fault | output | 1 | Access refused, one-cycle pulse |
| res_hit | output | 1 | A region decided |
| res_region | output | 3 | Index of the deciding region |

## Verification
Every result is due on the first rising edge after the access strobe, so the bench predicts the outcome from the inputs and its own copy of the settings before that edge and compares all five result outputs at the following falling edge. Settings writes are folded into the bench's model only after that same edge, which makes an access issued together with a write be judged on the old settings, as R11 asks. Idle cycles are compared too, so any stray result or pulse is caught in the cycle it appears.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int ADDR_W = 32;
    localparam int LG_W   = 6;
    localparam int MIN_LG = 5;
    localparam int SUB_N  = 8;
    localparam int SUB_W  = 3;
    localparam int PERM_W = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_EXEC2 = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LG_W-1:0]   lg;
        logic              on;
        logic [SUB_N-1:0]  sub_off;
        logic [PERM_W-1:0] perm;
        logic              xn;
    } region_cfg_t;

    typedef struct packed {
        logic permit;
        logic hit;
    } verdict_t;

    function automatic logic [LG_W-1:0] clamp_lg(input logic [LG_W-1:0] v);
        if (v < LG_W'(MIN_LG))
            return LG_W'(MIN_LG);
        else if (v > LG_W'(ADDR_W))
            return LG_W'(ADDR_W);
        else
            return v;
    endfunction

    function automatic logic may_read(input logic [PERM_W-1:0] perm, input logic priv);
        case (perm)
            3'b001, 3'b101:         return priv;
            3'b010, 3'b011, 3'b110: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

    function automatic logic may_write(input logic [PERM_W-1:0] perm, input logic priv);
        case (perm)
            3'b001, 3'b010: return priv;
            3'b011:         return 1'b1;
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mpc_cfg_bank.sv
module mpc_cfg_bank
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  region_cfg_t                   wr_cfg,
    input  logic                          ctl_we,
    input  logic                          ctl_guard_en,
    input  logic                          ctl_bg_en,
    output region_cfg_t [NUM_REGIONS-1:0] cfg_vec,
    output logic                          guard_en,
    output logic                          bg_en
);

    region_cfg_t wr_clean;

    always_comb begin
        wr_clean    = wr_cfg;
        wr_clean.lg = clamp_lg(wr_cfg.lg);
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_vec[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                cfg_vec[r] <= wr_clean;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            guard_en <= 1'b0;
            bg_en    <= 1'b0;
        end else if (ctl_we) begin
            guard_en <= ctl_guard_en;
            bg_en    <= ctl_bg_en;
        end
    end

endmodule

// File: rtl/mpc_region_match.sv
module mpc_region_match
    import mpc_pkg::*;
(
    input  region_cfg_t       cfg,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    input  logic              priv,
    output logic              hit,
    output logic              allow
);

    logic [ADDR_W:0]   low_mask_w;
    logic [ADDR_W-1:0] keep_mask;
    logic              in_span;
    logic [LG_W-1:0]   sub_shift;
    logic [ADDR_W-1:0] shifted;
    logic [SUB_W-1:0]  sub_idx;
    logic              rd_ok;
    logic              wr_ok;

    always_comb begin
        low_mask_w = ((ADDR_W+1)'(1) << cfg.lg) - (ADDR_W+1)'(1);
        keep_mask  = ~low_mask_w[ADDR_W-1:0];
        in_span    = ((addr ^ cfg.base) & keep_mask) == '0;
        sub_shift  = cfg.lg - LG_W'(SUB_W);
        shifted    = addr >> sub_shift;
        sub_idx    = shifted[SUB_W-1:0];
        hit        = cfg.on && in_span && !cfg.sub_off[sub_idx];
    end

    always_comb begin
        rd_ok = may_read(cfg.perm, priv);
        wr_ok = may_write(cfg.perm, priv);
        case (acc_kind_e'(kind))
            ACC_READ:  allow = rd_ok;
            ACC_WRITE: allow = wr_ok;
            default:   allow = rd_ok && !cfg.xn;
        endcase
    end

endmodule

// File: rtl/mpc_pick.sv
module mpc_pick #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hit_vec,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (hit_vec[r]) begin
                found = 1'b1;
                idx   = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
    import mpc_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_base,
    input  logic [5:0]        cfg_size_lg,
    input  logic              cfg_on,
    input  logic [7:0]        cfg_sub_off,
    input  logic [2:0]        cfg_perm,
    input  logic              cfg_xn,
    input  logic              ctl_we,
    input  logic              ctl_guard_en,
    input  logic              ctl_bg_en,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_priv,
    output logic              res_valid,
    output logic              res_permit,
    output logic              res_fault,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_region
);

    region_cfg_t                   wr_cfg;
    region_cfg_t [NUM_REGIONS-1:0] cfg_vec;
    logic                          guard_en_q;
    logic                          bg_en_q;
    logic [NUM_REGIONS-1:0]        hit_vec;
    logic [NUM_REGIONS-1:0]        allow_vec;
    logic                          any_hit;
    logic [IDX_W-1:0]              win_idx;
    verdict_t                      verdict;

    always_comb begin
        wr_cfg.base    = cfg_base;
        wr_cfg.lg      = cfg_size_lg;
        wr_cfg.on      = cfg_on;
        wr_cfg.sub_off = cfg_sub_off;
        wr_cfg.perm    = cfg_perm;
        wr_cfg.xn      = cfg_xn;
    end

    mpc_cfg_bank #(.NUM_REGIONS(NUM_REGIONS)) bank_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg_we),
        .wr_idx       (cfg_idx),
        .wr_cfg       (wr_cfg),
        .ctl_we       (ctl_we),
        .ctl_guard_en (ctl_guard_en),
        .ctl_bg_en    (ctl_bg_en),
        .cfg_vec      (cfg_vec),
        .guard_en     (guard_en_q),
        .bg_en        (bg_en_q)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
        mpc_region_match match_i (
            .cfg   (cfg_vec[r]),
            .addr  (acc_addr),
            .kind  (acc_kind),
            .priv  (acc_priv),
            .hit   (hit_vec[r]),
            .allow (allow_vec[r])
        );
    end

    mpc_pick #(.NUM_REGIONS(NUM_REGIONS)) pick_i (
        .hit_vec (hit_vec),
        .found   (any_hit),
        .idx     (win_idx)
    );

    always_comb begin
        if (!guard_en_q) begin
            verdict.permit = 1'b1;
            verdict.hit    = 1'b0;
        end else if (any_hit) begin
            verdict.permit = allow_vec[win_idx];
            verdict.hit    = 1'b1;
        end else begin
            verdict.permit = bg_en_q && acc_priv;
            verdict.hit    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_permit <= 1'b0;
            res_fault  <= 1'b0;
            res_hit    <= 1'b0;
            res_region <= '0;
        end else begin
            res_valid  <= acc_valid;
            res_permit <= acc_valid && verdict.permit;
            res_fault  <= acc_valid && !verdict.permit;
            res_hit    <= acc_valid && verdict.hit;
            res_region <= (acc_valid && verdict.hit) ? win_idx : '0;
        end
    end

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_permit && !res_fault && !res_hit && res_region == '0));

    // R2
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones({res_permit, res_fault}) == 1);

    // R9
    guard_off_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !guard_en_q) |=> (res_permit && !res_hit));

    // R8
    no_region_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && guard_en_q && !any_hit && !(bg_en_q && acc_priv)) |=> res_fault);

    // R4
    pick_top_chk: assert property (@(posedge clk) disable iff (rst)
        (any_hit && hit_vec[NUM_REGIONS-1]) |-> (win_idx == IDX_W'(NUM_REGIONS-1)));

endmodule

// File: tb/mem_region_guard_tb_top.sv
module mem_region_guard_tb_top;

    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_base;
    logic [5:0]  cfg_size_lg;
    logic        cfg_on;
    logic [7:0]  cfg_sub_off;
    logic [2:0]  cfg_perm;
    logic        cfg_xn;
    logic        ctl_we;
    logic        ctl_guard_en;
    logic        ctl_bg_en;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_kind;
    logic        acc_priv;
    logic        res_valid;
    logic        res_permit;
    logic        res_fault;
    logic        res_hit;
    logic [2:0]  res_region;

    always #5 clk = ~clk;

    mem_region_guard #(.NUM_REGIONS(NR)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_size_lg(cfg_size_lg), .cfg_on(cfg_on), .cfg_sub_off(cfg_sub_off),
        .cfg_perm(cfg_perm), .cfg_xn(cfg_xn),
        .ctl_we(ctl_we), .ctl_guard_en(ctl_guard_en), .ctl_bg_en(ctl_bg_en),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
        .acc_priv(acc_priv),
        .res_valid(res_valid), .res_permit(res_permit), .res_fault(res_fault),
        .res_hit(res_hit), .res_region(res_region)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench-side settings
    longint unsigned m_base [NR];
    int              m_lg   [NR];
    bit              m_on   [NR];
    bit [7:0]        m_off  [NR];
    int              m_perm [NR];
    bit              m_xn   [NR];
    bit              m_guard;
    bit              m_bg;

    function automatic bit perm_allows(int perm, bit priv, int kind, bit xn);
        bit rd, wr;
        rd = 0; wr = 0;
        if (perm == 1)      begin rd = priv; wr = priv; end
        else if (perm == 2) begin rd = 1;    wr = priv; end
        else if (perm == 3) begin rd = 1;    wr = 1;    end
        else if (perm == 5) begin rd = priv; end
        else if (perm == 6) begin rd = 1;    end
        if (kind == 0) return rd;
        if (kind == 1) return wr;
        return rd && !xn;
    endfunction

    task automatic predict(input bit [31:0] a, input int kind, input bit priv,
                           output bit permit, output bit hit, output int region);
        longint unsigned span, lo, ad, piece;
        int sub;
        permit = 1; hit = 0; region = 0;
        if (!m_guard) return;
        ad = longint'(a);
        for (int r = NR - 1; r >= 0; r--) begin
            if (!m_on[r]) continue;
            span  = 64'd1 << m_lg[r];
            lo    = m_base[r] - (m_base[r] % span);
            if (ad < lo || ad >= lo + span) continue;
            piece = span / 8;
            sub   = int'((ad - lo) / piece);
            if (m_off[r][sub]) continue;
            hit    = 1;
            region = r;
            permit = perm_allows(m_perm[r], priv, kind, m_xn[r]);
            return;
        end
        permit = m_bg && priv;
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_size_lg = 0; cfg_on = 0;
        cfg_sub_off = 0; cfg_perm = 0; cfg_xn = 0;
        ctl_we = 0; ctl_guard_en = 0; ctl_bg_en = 0;
        acc_valid = 0; acc_addr = 0; acc_kind = 0; acc_priv = 0;
    endtask

    // one clock: predict, edge, fold settings, compare at the falling edge
    task automatic run(input string tag);
        bit e_valid, e_permit, e_hit;
        int e_region, lg;
        e_valid = acc_valid;
        predict(acc_addr, int'(acc_kind), acc_priv, e_permit, e_hit, e_region);
        @(posedge clk);
        if (cfg_we) begin
            lg = int'(cfg_size_lg);
            if (lg < 5) lg = 5;
            if (lg > 32) lg = 32;
            m_base[cfg_idx] = longint'(cfg_base);
            m_lg[cfg_idx]   = lg;
            m_on[cfg_idx]   = cfg_on;
            m_off[cfg_idx]  = cfg_sub_off;
            m_perm[cfg_idx] = int'(cfg_perm);
            m_xn[cfg_idx]   = cfg_xn;
        end
        if (ctl_we) begin
            m_guard = ctl_guard_en;
            m_bg    = ctl_bg_en;
        end
        @(negedge clk);
        tests++;
        if (!e_valid) begin
            if ({res_valid, res_permit, res_fault, res_hit, res_region} != '0) begin
                fails++;
                $display("FAIL %s idle: got v=%0b p=%0b f=%0b h=%0b r=%0d expected all 0",
                         tag, res_valid, res_permit, res_fault, res_hit, res_region);
            end
        end else if (res_valid !== 1'b1 || res_permit !== e_permit || res_fault !== !e_permit ||
                     res_hit !== e_hit || int'(res_region) != e_region) begin
            fails++;
            $display("FAIL %s addr=%h kind=%0d priv=%0b: got v=%0b p=%0b f=%0b h=%0b r=%0d expected v=1 p=%0b f=%0b h=%0b r=%0d",
                     tag, acc_addr, acc_kind, acc_priv, res_valid, res_permit, res_fault,
                     res_hit, res_region, e_permit, !e_permit, e_hit, e_region);
        end
    endtask

    task automatic set_region(input int idx, input bit [31:0] base, input int lg, input bit on,
                              input bit [7:0] off, input int perm, input bit xn, input string tag);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size_lg = 6'(lg);
        cfg_on = on; cfg_sub_off = off; cfg_perm = 3'(perm); cfg_xn = xn;
        run(tag);
        cfg_we = 0;
    endtask

    task automatic set_ctl(input bit guard, input bit bg, input string tag);
        ctl_we = 1; ctl_guard_en = guard; ctl_bg_en = bg;
        run(tag);
        ctl_we = 0;
    endtask

    task automatic access(input bit [31:0] a, input int kind, input bit priv, input string tag);
        acc_valid = 1; acc_addr = a; acc_kind = 2'(kind); acc_priv = priv;
        run(tag);
        acc_valid = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no end of run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_base[r] = 0; m_lg[r] = 5; m_on[r] = 0; m_off[r] = 0; m_perm[r] = 0; m_xn[r] = 0;
        end
        m_guard = 0; m_bg = 0;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset
        tests++;
        if ({res_valid, res_permit, res_fault, res_hit, res_region} != '0) begin
            fails++;
            $display("FAIL R1 reset outputs: got %b expected 0",
                     {res_valid, res_permit, res_fault, res_hit, res_region});
        end
        rst = 0;
        run("R1");
        // R1: settings cleared, so guard is off and everything passes
        access(32'h1234_5678, 1, 0, "R1");
        // R9: guard off permits all kinds
        for (int k = 0; k < 4; k++) access(32'hFFFF_FFF0, k, 0, "R9");
        set_region(0, 32'h2000_0000, 12, 1, 8'h00, 3, 0, "R9");
        access(32'h2000_0010, 1, 0, "R9");
        // R11: control write together with an access uses old guard setting
        ctl_we = 1; ctl_guard_en = 1; ctl_bg_en = 0;
        acc_valid = 1; acc_addr = 32'h5000_0000; acc_kind = 0; acc_priv = 0;
        run("R11");
        ctl_we = 0; acc_valid = 0;
        // R3: inside and at edges of a 4 KB region
        access(32'h2000_0000, 0, 0, "R3");
        access(32'h2000_0FFF, 1, 0, "R3");
        access(32'h2000_1000, 0, 1, "R7");
        access(32'h1FFF_FFFF, 0, 1, "R7");
        // R2: back-to-back strobes then idle
        access(32'h2000_0004, 2, 1, "R2");
        run("R2");
        // R4: overlap, higher index wins
        set_region(3, 32'h2000_0400, 10, 1, 8'h00, 5, 0, "R4");
        access(32'h2000_0410, 1, 1, "R4");
        access(32'h2000_0410, 0, 1, "R4");
        access(32'h2000_0410, 0, 0, "R4");
        access(32'h2000_0810, 1, 0, "R4");
        // R5: disable sub-region 2 of region 3 (offsets 0x100..0x17F)
        set_region(3, 32'h2000_0400, 10, 1, 8'h04, 5, 0, "R5");
        access(32'h2000_0510, 1, 0, "R5");
        access(32'h2000_057F, 1, 0, "R5");
        access(32'h2000_0580, 1, 0, "R5");
        access(32'h2000_04FF, 0, 1, "R5");
        // R6: whole permission table
        for (int p = 0; p < 8; p++) begin
            for (int x = 0; x < 2; x++) begin
                set_region(1, 32'h4000_0000, 8, 1, 8'h00, p, x[0], "R6");
                for (int pr = 0; pr < 2; pr++)
                    for (int k = 0; k < 4; k++)
                        access(32'h4000_0080, k, pr[0], "R6");
            end
        end
        // R7: unmatched faults with background off
        access(32'h6000_0000, 0, 1, "R7");
        // R8: background map
        set_ctl(1, 1, "R8");
        access(32'h6000_0000, 0, 1, "R8");
        access(32'h6000_0000, 2, 1, "R8");
        access(32'h6000_0000, 1, 0, "R8");
        access(32'h2000_0510, 1, 1, "R8");
        // R5: all sub-regions of region 0 off, background decides
        set_region(0, 32'h2000_0000, 12, 1, 8'hFF, 3, 0, "R5");
        access(32'h2000_0010, 0, 0, "R5");
        access(32'h2000_0010, 0, 1, "R5");
        // R3: full-space region and size clamps
        set_region(7, 32'h0000_0000, 40, 1, 8'h00, 6, 1, "R3");
        access(32'hFFFF_FFFC, 0, 0, "R3");
        access(32'h0000_0000, 1, 1, "R3");
        access(32'h8000_0000, 2, 1, "R3");
        set_region(7, 32'h0000_0000, 40, 1, 8'h80, 6, 0, "R3");
        access(32'hF000_0000, 0, 0, "R3");
        access(32'hE000_0000, 2, 0, "R3");
        set_region(7, 32'h0, 5, 0, 8'h00, 0, 0, "R3");
        set_region(6, 32'h3000_0040, 2, 1, 8'h00, 3, 0, "R3");
        access(32'h3000_005F, 1, 0, "R3");
        access(32'h3000_0060, 1, 0, "R3");
        access(32'h3000_003F, 1, 0, "R3");
        // R10: unaligned base
        set_region(5, 32'h7000_0ABC, 12, 1, 8'h00, 3, 0, "R10");
        access(32'h7000_0000, 1, 0, "R10");
        access(32'h7000_0FFF, 1, 0, "R10");
        access(32'h7000_1000, 1, 0, "R10");
        // R11: region write alongside access sees old entry, next sees new
        cfg_we = 1; cfg_idx = 5; cfg_base = 32'h7000_0000; cfg_size_lg = 12; cfg_on = 1;
        cfg_sub_off = 0; cfg_perm = 0; cfg_xn = 0;
        acc_valid = 1; acc_addr = 32'h7000_0100; acc_kind = 1; acc_priv = 0;
        run("R11");
        cfg_we = 0;
        run("R11");
        acc_valid = 0;
        // R9: turning guard off again
        set_ctl(0, 1, "R9");
        access(32'h7000_0100, 1, 0, "R9");
        run("R2");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule